// File: doc/BRIEF.md
# Soft-Start Reference Ramp Sequencer

This block produces the digital reference code that a regulator's error loop follows while its output comes up. After power is good and the enable is high, the code starts at zero and climbs by one step on each switching-cycle strobe. The start-up time is therefore a count of switching periods, not a fixed time. The code stops at a final value that lies above the regulation reference.

As the code climbs it passes three thresholds, and each one raises a registered flag for the rest of the controller:
- **Synchronous-rectifier enable.** This comes first, at 95% of the reference. Holding off low-side drive until this point keeps a pre-charged output from being pulled down.
- **In regulation.** This comes next, when the code equals the reference.
- **Sequence done.** This comes last, at the final code (125% of the reference). It lets the other protections and the power-good output take effect.

A feedback-pin short seen before release keeps the ramp parked at zero. Dropping the enable or losing supply-OK clears everything, and the sequence restarts from zero.

Top module: `ss_ramp_seq`

## Requirements
- R1: After reset, `ramp_code` is 0 and `sync_rect_en`, `in_reg` and `ss_done` are all low.
- R2: The ramp is released only in a cycle where `en`=1, `uvlo_ok`=1 and `fb_short`=0. The release takes effect at that clock edge. Until then, strobes leave `ramp_code` at 0.
- R3: While `fb_short`=1 the ramp is not released. Once it has been released, `fb_short` has no effect on the code or the flags.
- R4: After release, every clock edge that samples `cyc_stb`=1 raises `ramp_code` by exactly 1, visible after that edge. A strobe held high for N cycles adds N. Without a strobe the code holds.
- R5: `ramp_code` saturates at DONE = REF_CODE*DONE_PCT/100, which is 40 for REF_CODE=32 and DONE_PCT=125. Further strobes leave it there.
- R6: `sync_rect_en` goes high one clock after `ramp_code` first reaches SYNC = floor(REF_CODE*SYNC_PCT/100), which is 30 for REF_CODE=32 and SYNC_PCT=95.
- R7: `in_reg` goes high one clock after `ramp_code` first reaches REF_CODE.
- R8: `ss_done` goes high one clock after `ramp_code` first reaches DONE. `ss_done` never rises ahead of `in_reg`, and `in_reg` never rises ahead of `sync_rect_en`.
- R9: A clock edge that samples `en`=0 or `uvlo_ok`=0 clears `ramp_code` to 0 and lowers all three flags at that edge. When the conditions return, the sequence starts again from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_stb | input | 1 | One-clock strobe at the start of each switching cycle |
| en | input | 1 | Enable level |
| uvlo_ok | input | 1 | Supply above the lockout threshold |
| fb_short | input | 1 | Feedback-pin check reports a short |
| ramp_code | output | CODE_W | Reference code for the DAC |
| sync_rect_en | output | 1 | Low-side synchronous drive permitted |
| in_reg | output | 1 | Ramp has reached the regulation reference |
| ss_done | output | 1 | Ramp finished; fault checks and power-good enabled |

## Verification
`ramp_code` changes at the edge that samples a strobe. The three flags follow one edge later. A clear caused by enable or supply-OK lands on the code and the flags at the same edge.

The bench drives every input on a falling edge and pulses each strobe for one clock. It then waits one further falling edge before comparing, so both the code and the flags have settled.

The bench sweeps the small configuration one strobe at a time from zero through several strobes past saturation. At each step, the expected code and the expected flags are computed as minimums and threshold comparisons.

// File: rtl/ss_pkg.sv
`timescale 1ns/1ps
package ss_pkg;
  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_RUN = 1'b1} seq_state_t;
  localparam int MS_SYNC  = 0;
  localparam int MS_REG   = 1;
  localparam int MS_DONE  = 2;
  localparam int MS_COUNT = 3;
endpackage

// File: rtl/ss_gate.sv
`timescale 1ns/1ps
module ss_gate
  import ss_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic uvlo_ok,
  input  logic fb_short,
  output logic abort,
  output logic running
);
  seq_state_t state_q;

  assign abort   = ~(en & uvlo_ok);
  assign running = (state_q == SEQ_RUN);

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      state_q <= SEQ_IDLE;
    end else if (state_q == SEQ_IDLE && !fb_short) begin
      state_q <= SEQ_RUN;
    end
  end

  // R3: a short seen while idle keeps the ramp parked
  assert_short_blocks_R3: assert property (@(posedge clk) disable iff (rst)
    (!running && fb_short) |=> !running);
  // R9: losing enable or supply drops the sequence
  assert_abort_idle_R9: assert property (@(posedge clk) disable iff (rst)
    abort |=> !running);
endmodule

// File: rtl/ss_ramp_cnt.sv
`timescale 1ns/1ps
module ss_ramp_cnt #(
  parameter int CODE_W    = 8,
  parameter int DONE_CODE = 250
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort,
  input  logic              running,
  input  logic              cyc_stb,
  output logic [CODE_W-1:0] code
);
  localparam logic [CODE_W-1:0] TOP = CODE_W'(DONE_CODE);

  logic [CODE_W-1:0] code_q;
  assign code = code_q;

  always_ff @(posedge clk) begin
    if (rst || abort || !running) begin
      code_q <= '0;
    end else if (cyc_stb && code_q < TOP) begin
      code_q <= code_q + 1'b1;
    end
  end

  assert_cap_R5: assert property (@(posedge clk) disable iff (rst)
    code_q <= TOP);
  assert_single_step_R4: assert property (@(posedge clk) disable iff (rst)
    (!abort && running) |=> (code_q == $past(code_q)) || (code_q == $past(code_q) + 1'b1));
  assert_no_stb_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!abort && !cyc_stb) |=> $stable(code_q));
endmodule

// File: rtl/ss_milestone.sv
`timescale 1ns/1ps
module ss_milestone #(
  parameter int CODE_W = 8,
  parameter int THR    = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [CODE_W-1:0] code,
  output logic              hit
);
  localparam logic [CODE_W-1:0] THR_C = CODE_W'(THR);

  logic hit_q;
  assign hit = hit_q;

  always_ff @(posedge clk) begin
    if (rst || clr) hit_q <= 1'b0;
    else            hit_q <= (code >= THR_C);
  end

  assert_clear_low_R9: assert property (@(posedge clk) disable iff (rst)
    clr |=> !hit_q);
endmodule

// File: rtl/ss_ramp_seq.sv
`timescale 1ns/1ps
module ss_ramp_seq
  import ss_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int REF_CODE = 200,
  parameter int SYNC_PCT = 95,
  parameter int DONE_PCT = 125
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_stb,
  input  logic              en,
  input  logic              uvlo_ok,
  input  logic              fb_short,
  output logic [CODE_W-1:0] ramp_code,
  output logic              sync_rect_en,
  output logic              in_reg,
  output logic              ss_done
);
  localparam int SYNC_CODE = (REF_CODE * SYNC_PCT) / 100;
  localparam int DONE_CODE = (REF_CODE * DONE_PCT) / 100;
  localparam int THR [MS_COUNT] = '{SYNC_CODE, REF_CODE, DONE_CODE};

  logic abort;
  logic running;
  logic [MS_COUNT-1:0] flags;

  ss_gate u_gate (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .uvlo_ok  (uvlo_ok),
    .fb_short (fb_short),
    .abort    (abort),
    .running  (running)
  );

  ss_ramp_cnt #(.CODE_W(CODE_W), .DONE_CODE(DONE_CODE)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .abort   (abort),
    .running (running),
    .cyc_stb (cyc_stb),
    .code    (ramp_code)
  );

  for (genvar g = 0; g < MS_COUNT; g++) begin : g_ms
    ss_milestone #(.CODE_W(CODE_W), .THR(THR[g])) u_ms (
      .clk  (clk),
      .rst  (rst),
      .clr  (abort),
      .code (ramp_code),
      .hit  (flags[g])
    );
  end

  assign sync_rect_en = flags[MS_SYNC];
  assign in_reg       = flags[MS_REG];
  assign ss_done      = flags[MS_DONE];

  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (rst)
    !running |-> ramp_code == '0);
  assert_done_after_reg_R8: assert property (@(posedge clk) disable iff (rst)
    ss_done |-> in_reg);
  assert_reg_after_sync_R7: assert property (@(posedge clk) disable iff (rst)
    in_reg |-> sync_rect_en);
  assert_abort_clears_R9: assert property (@(posedge clk) disable iff (rst)
    abort |=> (ramp_code == '0) && !sync_rect_en);
endmodule

// File: tb/test_ss_ramp_seq.sv
`timescale 1ns/1ps
module test_ss_ramp_seq;
  localparam int CW   = 6;
  localparam int REF  = 32;
  localparam int SYNC = (REF * 95) / 100;
  localparam int DONE = (REF * 125) / 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc_stb = 1'b0;
  logic en = 1'b0;
  logic uvlo_ok = 1'b0;
  logic fb_short = 1'b0;
  logic [CW-1:0] ramp_code;
  logic sync_rect_en, in_reg, ss_done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ss_ramp_seq #(.CODE_W(CW), .REF_CODE(REF), .SYNC_PCT(95), .DONE_PCT(125)) i_ss_ramp_seq (
    .clk(clk), .rst(rst), .cyc_stb(cyc_stb), .en(en), .uvlo_ok(uvlo_ok),
    .fb_short(fb_short), .ramp_code(ramp_code), .sync_rect_en(sync_rect_en),
    .in_reg(in_reg), .ss_done(ss_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input int code);
    chk({req, " code"}, int'(ramp_code), code);
    chk({req, " sync"}, int'(sync_rect_en), int'(code >= SYNC));
    chk({req, " inreg"}, int'(in_reg), int'(code >= REF));
    chk({req, " done"}, int'(ss_done), int'(code >= DONE));
  endtask

  task automatic pulse(input int n);
    cyc_stb = 1'b1;
    repeat (n) @(negedge clk);
    cyc_stb = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_all("R1 reset", 0);

    // R2: no release without both enable and supply-OK
    uvlo_ok = 1'b1; en = 1'b0;
    @(negedge clk);
    pulse(1); pulse(1);
    chk_all("R2 en low", 0);
    uvlo_ok = 1'b0; en = 1'b1;
    @(negedge clk);
    pulse(1); pulse(1);
    chk_all("R2 uvlo low", 0);

    // R3: short holds the ramp at zero
    fb_short = 1'b1; uvlo_ok = 1'b1;
    @(negedge clk);
    pulse(1); pulse(3);
    chk_all("R3 short blocks", 0);
    fb_short = 1'b0;
    @(negedge clk);

    // R4..R8 sweep one strobe at a time past saturation
    for (int k = 1; k <= DONE + 4; k++) begin
      if (k == 10) fb_short = 1'b1;   // R3: ignored after release
      pulse(1);
      @(negedge clk);
      chk_all(k <= DONE ? "R4 R6 R7 R8 step" : "R5 saturate", (k < DONE) ? k : DONE);
      if (k == 5) begin
        repeat (4) @(negedge clk);
        chk("R4 hold without strobe", int'(ramp_code), 5);
      end
    end
    fb_short = 1'b0;

    // R9: enable drop clears at the next edge
    en = 1'b0;
    @(negedge clk);
    chk_all("R9 en drop", 0);
    en = 1'b1;
    @(negedge clk);
    for (int k = 1; k <= 35; k++) pulse(1);
    @(negedge clk);
    chk_all("R9 reramp", 35);
    uvlo_ok = 1'b0;
    @(negedge clk);
    chk_all("R9 uvlo drop", 0);
    uvlo_ok = 1'b1;
    @(negedge clk);
    pulse(1);
    @(negedge clk);
    chk_all("R9 restart from zero", 1);

    // R4: a strobe held three cycles adds three
    pulse(3);
    @(negedge clk);
    chk_all("R4 held strobe", 4);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule